// File: doc/BRIEF.md
# ADC Autoscan Conversion Sequencer

This block is the digital controller in front of a sixteen-input successive-approximation converter. Software picks a first channel. Once started, the block converts that channel and every channel above it, one conversion per channel, up to the top channel 15. For each conversion it produces the sample and convert timing from a prescaler setting. It exchanges a start pulse and a done pulse with the analog front end, which returns a 10-bit result. The block writes that result into a register kept for the channel and raises an end-of-scan flag when channel 15 completes.

A scan begins when the start bit is set. Software can set it with a write pulse. Two hardware trigger inputs, one external and one internal, can also set it, and each has its own enable. In single mode the block clears the start bit itself after channel 15 and then waits. In continuous mode it returns to the first channel and keeps going until software clears the start bit. A power-down control stops any new conversion from starting.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A scan converts channels in ascending order, beginning at `cfg_start_ch` and ending with channel 15. The channel under conversion appears on `afe_ch` while `afe_start` is high. With `cfg_start_ch` = 15 exactly one conversion (channel 15) occurs, and with 3 the channels 3..15 are converted.
- R2: The start bit (`start_bit`) is set from idle by `sw_start_set`, or by `ext_trig` when `cfg_ext_en` = 1, or by `int_trig` when `cfg_int_en` = 1. A disabled trigger has no effect. `start_bit` reads 1 in the cycle after the request. Start requests that arrive while a conversion is in progress have no effect.
- R3: In single mode (`cfg_cont` = 0), `start_bit` clears when the channel 15 conversion completes, and the block stays idle with `converting` = 0.
- R4: In continuous mode (`cfg_cont` = 1), the conversion that follows channel 15 uses the channel in `cfg_start_ch`, and scanning repeats until the start bit is cleared.
- R5: `eoc_flag` is set when a channel 15 conversion completes while the start bit is still 1, in either mode. It stays set until `eoc_clr` is pulsed. When the set and a clear fall in the same cycle, the set wins.
- R6: Each channel has a 10-bit result register, read through `rd_data` for the channel on `rd_ch` (combinational read). A completed conversion overwrites the register of its channel. All registers reset to 0.
- R7: With P = `cfg_prescale`, where a value of 0 counts as 1, `afe_start` is a one-cycle pulse at the start of each conversion. Back-to-back conversions start 56·P cycles apart, and `afe_sample` is high for the first 16·P cycles of each conversion.
- R8: `sw_start_clr` clears the start bit, and it wins over a set in the same cycle. The conversion in progress still completes and stores its result. The block then goes idle without setting `eoc_flag`.
- R9: While `cfg_pdown` = 1, start requests have no effect and no conversion begins. Raising it in the middle of a scan acts as a stop under R8.
- R10: After reset, `start_bit`, `converting`, `eoc_flag` and `afe_start` are 0.
- R11: A conversion completes at whichever comes later: the end of its 56·P window or the cycle after the `afe_done` pulse, if that pulse arrives after the window has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_ch | input | 4 | First channel of a scan |
| cfg_cont | input | 1 | 1 = continuous scan, 0 = single scan |
| cfg_pdown | input | 1 | Power-down: blocks new conversions |
| cfg_prescale | input | 3 | Prescaler value P (0 treated as 1) |
| cfg_ext_en | input | 1 | Enable for the external trigger |
| cfg_int_en | input | 1 | Enable for the internal trigger |
| sw_start_set | input | 1 | Software pulse setting the start bit |
| sw_start_clr | input | 1 | Software pulse clearing the start bit |
| ext_trig | input | 1 | External trigger pulse |
| int_trig | input | 1 | Internal trigger pulse |
| eoc_clr | input | 1 | Clears the end-of-scan flag |
| rd_ch | input | 4 | Result register select |
| rd_data | output | 10 | Result of the selected channel |
| afe_start | output | 1 | One-cycle pulse starting a conversion |
| afe_sample | output | 1 | High during the sample phase |
| afe_ch | output | 4 | Channel being converted |
| afe_done | input | 1 | Front end reports the result is valid |
| afe_result | input | 10 | Conversion result from the front end |
| start_bit | output | 1 | Current state of the start bit |
| converting | output | 1 | A conversion is in progress |
| eoc_flag | output | 1 | End-of-scan flag |

## Verification
The completion of channel 15 sets the end-of-scan flag. A software clear of that flag can arrive in the same cycle. The bench finds the `afe_start` pulse for channel 15 at P = 1 and counts 56 cycles from it so that `eoc_clr` is sampled at the completion edge. It then expects the flag to read 1. A second pairing, a stop pulse during a continuous scan, is judged by the number of conversions and by the stored result of the conversion that was allowed to finish.

// File: rtl/adc_scan_pkg.sv
// Package: shared types of the autoscan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_scan_pkg;

    // Sequencer state: waiting, or one conversion in flight
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_t;

endpackage

// File: rtl/adc_scan_timer.sv
// Module: per-conversion timing generator.
// Counts system clocks from the start of a conversion. It flags the sample
// phase (2*SAMPLE_MUL*P cycles) and the end of the conversion window
// (2*CONV_MUL*P cycles), with P the prescaler value and 0 mapped to 1.
// Assumes: restart is pulsed in the cycle a conversion is launched.
module adc_scan_timer #(
    parameter int PR_W       = 3,
    parameter int SAMPLE_MUL = 8,
    parameter int CONV_MUL   = 28,
    localparam int PR_MAX    = (1 << PR_W) - 1,
    localparam int CNT_W     = $clog2(2 * CONV_MUL * PR_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            restart,
    input  logic [PR_W-1:0] prescale,
    output logic            sample,
    output logic            first,
    output logic            win_end
);

    logic [PR_W-1:0]  pr_eff;
    logic [CNT_W-1:0] sample_len;
    logic [CNT_W-1:0] conv_len;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: map the illegal prescaler value 0 to 1 and derive phase lengths
    always_comb begin
        pr_eff     = (prescale == '0) ? PR_W'(1) : prescale;
        sample_len = CNT_W'(2 * SAMPLE_MUL) * CNT_W'(pr_eff);
        conv_len   = CNT_W'(2 * CONV_MUL) * CNT_W'(pr_eff);
    end

    // Purpose: count cycles within a conversion, holding at the window end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (active && !win_end) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: decode phase outputs from the count
    always_comb begin
        win_end = (cnt_q >= conv_len - 1'b1);
        sample  = active && (cnt_q < sample_len);
        first   = active && (cnt_q == '0);
    end

    // R7: the sample phase always lies inside the conversion window
    a_r7_sample_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !win_end);

    // R11: the count holds at the window end while waiting for the front end
    a_r11_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (active && win_end && !restart) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/adc_scan_results.sv
// Module: per-channel result register bank.
// One RES_W register per channel, written on a completed conversion and read
// combinationally through a channel select.
// Assumes: wr_addr and rd_addr are below N_CH.
module adc_scan_results #(
    parameter int N_CH   = 16,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_addr,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_addr,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] regs_q [N_CH];
    logic [N_CH-1:0]  hit;

    // Purpose: one write strobe per channel register
    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_hit
            assign hit[g] = wr_en && (wr_addr == CH_W'(g));
        end
    endgenerate

    // Purpose: store results, clearing all registers on reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_CH; i++) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (hit[i]) begin
                regs_q[i] <= wr_data;
            end
        end
    end

    // Purpose: combinational read port
    assign rd_data = regs_q[rd_addr];

    // R6: a write lands in the addressed register
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

    // R6: at most one register is written per cycle
    a_r6_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/adc_scan_seq.sv
// Module: scan sequencer.
// Holds the start bit, walks channels from the start channel to the top one,
// wraps in continuous mode, raises the end-of-scan flag and captures the
// front-end result for the register bank.
// Assumes: afe_done arrives at most once per conversion.
module adc_scan_seq #(
    parameter int N_CH   = 16,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  cfg_start_ch,
    input  logic             cfg_cont,
    input  logic             cfg_pdown,
    input  logic             cfg_ext_en,
    input  logic             cfg_int_en,
    input  logic             sw_start_set,
    input  logic             sw_start_clr,
    input  logic             ext_trig,
    input  logic             int_trig,
    input  logic             eoc_clr,
    input  logic             afe_done,
    input  logic [RES_W-1:0] afe_result,
    input  logic             win_end,
    output logic             active,
    output logic             restart,
    output logic [CH_W-1:0]  ch,
    output logic             wr_en,
    output logic [RES_W-1:0] wr_data,
    output logic             start_bit,
    output logic             eoc_flag
);
    import adc_scan_pkg::*;

    localparam logic [CH_W-1:0] TOP_CH = CH_W'(N_CH - 1);

    seq_state_t       state_q, state_d;
    logic [CH_W-1:0]  ch_q, ch_d;
    logic             run_q;
    logic             eoc_q;
    logic             got_q;
    logic [RES_W-1:0] res_q;
    logic             start_req, stop_req, conv_done, ch_last, keep_going;

    // Purpose: qualify start and stop requests
    always_comb begin
        start_req = !cfg_pdown && (state_q == SEQ_IDLE) && !run_q &&
                    (sw_start_set || (cfg_ext_en && ext_trig) ||
                     (cfg_int_en && int_trig));
        stop_req  = sw_start_clr || cfg_pdown;
    end

    // Purpose: detect completion of the current conversion
    always_comb begin
        active     = (state_q == SEQ_CONV);
        conv_done  = active && win_end && (got_q || afe_done);
        ch_last    = (ch_q == TOP_CH);
        keep_going = run_q && (cfg_cont || !ch_last);
    end

    // Purpose: next state and channel selection
    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        restart = 1'b0;
        case (state_q)
            SEQ_IDLE: begin
                if (run_q && !cfg_pdown) begin
                    state_d = SEQ_CONV;
                    ch_d    = cfg_start_ch;
                    restart = 1'b1;
                end
            end
            SEQ_CONV: begin
                if (conv_done) begin
                    if (keep_going) begin
                        restart = 1'b1;
                        ch_d    = ch_last ? cfg_start_ch : ch_q + 1'b1;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
            end
        endcase
    end

    // Purpose: state and channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    // Purpose: start bit; stop wins, then hardware clear, then set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (stop_req) begin
            run_q <= 1'b0;
        end else if (conv_done && ch_last && !cfg_cont) begin
            run_q <= 1'b0;
        end else if (start_req) begin
            run_q <= 1'b1;
        end
    end

    // Purpose: end-of-scan flag; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_q <= 1'b0;
        end else if (conv_done && ch_last && run_q) begin
            eoc_q <= 1'b1;
        end else if (eoc_clr) begin
            eoc_q <= 1'b0;
        end
    end

    // Purpose: capture the front-end result of the current conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_q <= 1'b0;
            res_q <= '0;
        end else if (restart) begin
            got_q <= 1'b0;
        end else if (afe_done && active) begin
            got_q <= 1'b1;
            res_q <= afe_result;
        end
    end

    assign ch        = ch_q;
    assign wr_en     = conv_done;
    assign wr_data   = afe_done ? afe_result : res_q;
    assign start_bit = run_q;
    assign eoc_flag  = eoc_q;

    // R1: the channel steps by one inside a scan
    a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !ch_last && run_q) |=> (ch_q == CH_W'($past(ch_q) + 1'b1)));

    // R2: requests arriving during a conversion cannot set the start bit
    a_r2_no_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !run_q) |=> !run_q);

    // R3: single mode clears the start bit after the top channel
    a_r3_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && ch_last && !cfg_cont) |=> !run_q);

    // R4: continuous mode wraps to the start channel
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && ch_last && cfg_cont && run_q) |=> (ch_q == $past(cfg_start_ch)));

    // R5: completing the top channel while running raises the flag
    a_r5_eoc_set: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && ch_last && run_q) |=> eoc_q);

    // R8: a completion with the start bit cleared returns to idle
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !run_q) |=> (state_q == SEQ_IDLE));

    // R9: power-down keeps the start bit clear
    a_r9_pdown_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pdown |=> !run_q);

endmodule

// File: rtl/adc_scan_ctrl.sv
// Module: top of the autoscan conversion sequencer.
// Ties the sequencer, the timing generator and the result bank together and
// presents the front-end start/done handshake.
// Assumes: the front end samples afe_ch while afe_start is high.
module adc_scan_ctrl #(
    parameter int N_CH       = 16,
    parameter int RES_W      = 10,
    parameter int PR_W       = 3,
    parameter int SAMPLE_MUL = 8,
    parameter int CONV_MUL   = 28,
    localparam int CH_W      = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  cfg_start_ch,
    input  logic             cfg_cont,
    input  logic             cfg_pdown,
    input  logic [PR_W-1:0]  cfg_prescale,
    input  logic             cfg_ext_en,
    input  logic             cfg_int_en,
    input  logic             sw_start_set,
    input  logic             sw_start_clr,
    input  logic             ext_trig,
    input  logic             int_trig,
    input  logic             eoc_clr,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data,
    output logic             afe_start,
    output logic             afe_sample,
    output logic [CH_W-1:0]  afe_ch,
    input  logic             afe_done,
    input  logic [RES_W-1:0] afe_result,
    output logic             start_bit,
    output logic             converting,
    output logic             eoc_flag
);

    logic             active, restart, win_end, first, wr_en;
    logic [CH_W-1:0]  ch;
    logic [RES_W-1:0] wr_data;

    adc_scan_seq #(.N_CH(N_CH), .RES_W(RES_W)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_start_ch (cfg_start_ch),
        .cfg_cont     (cfg_cont),
        .cfg_pdown    (cfg_pdown),
        .cfg_ext_en   (cfg_ext_en),
        .cfg_int_en   (cfg_int_en),
        .sw_start_set (sw_start_set),
        .sw_start_clr (sw_start_clr),
        .ext_trig     (ext_trig),
        .int_trig     (int_trig),
        .eoc_clr      (eoc_clr),
        .afe_done     (afe_done),
        .afe_result   (afe_result),
        .win_end      (win_end),
        .active       (active),
        .restart      (restart),
        .ch           (ch),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .start_bit    (start_bit),
        .eoc_flag     (eoc_flag)
    );

    adc_scan_timer #(.PR_W(PR_W), .SAMPLE_MUL(SAMPLE_MUL), .CONV_MUL(CONV_MUL)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .restart  (restart),
        .prescale (cfg_prescale),
        .sample   (afe_sample),
        .first    (first),
        .win_end  (win_end)
    );

    adc_scan_results #(.N_CH(N_CH), .RES_W(RES_W)) i_results (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ch),
        .wr_data (wr_data),
        .rd_addr (rd_ch),
        .rd_data (rd_data)
    );

    assign afe_start  = first;
    assign afe_ch     = ch;
    assign converting = active;

    // R7: the start pulse lasts a single cycle
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        afe_start |=> !afe_start);

    // R10: nothing is converting while the start bit has been clear for a cycle and the block was idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!converting && !start_bit) |=> !afe_start);

endmodule

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_start_ch = '0;
    logic       cfg_cont = 1'b0, cfg_pdown = 1'b0;
    logic [2:0] cfg_prescale = 3'd1;
    logic       cfg_ext_en = 1'b0, cfg_int_en = 1'b0;
    logic       sw_start_set = 1'b0, sw_start_clr = 1'b0;
    logic       ext_trig = 1'b0, int_trig = 1'b0, eoc_clr = 1'b0;
    logic [3:0] rd_ch = '0;
    logic [9:0] rd_data;
    logic       afe_start, afe_sample;
    logic [3:0] afe_ch;
    logic       afe_done = 1'b0;
    logic [9:0] afe_result = '0;
    logic       start_bit, converting, eoc_flag;

    int total = 0, bad = 0;
    int cyc = 0, lat = 5, pend = 0, last_cyc = 0, per = 0, samp_cnt = 0, seq_n = 0;
    logic [3:0] pch = '0;
    logic [3:0] seq [64];
    logic [5:0] gen = 6'd1;

    always #5 clk = ~clk;

    adc_scan_ctrl i_adc_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_start_ch(cfg_start_ch), .cfg_cont(cfg_cont),
        .cfg_pdown(cfg_pdown), .cfg_prescale(cfg_prescale), .cfg_ext_en(cfg_ext_en),
        .cfg_int_en(cfg_int_en), .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr),
        .ext_trig(ext_trig), .int_trig(int_trig), .eoc_clr(eoc_clr), .rd_ch(rd_ch),
        .rd_data(rd_data), .afe_start(afe_start), .afe_sample(afe_sample), .afe_ch(afe_ch),
        .afe_done(afe_done), .afe_result(afe_result), .start_bit(start_bit),
        .converting(converting), .eoc_flag(eoc_flag)
    );

    function automatic logic [9:0] model_val(input logic [3:0] c, input logic [5:0] g);
        return {c, g};
    endfunction

    // Front-end model and monitor, acting at falling edges
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            afe_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    afe_done   = 1'b1;
                    afe_result = model_val(pch, gen);
                end
            end
            if (afe_start) begin
                if (seq_n < 64) seq[seq_n] = afe_ch;
                seq_n++;
                per      = cyc - last_cyc;
                last_cyc = cyc;
                pch      = afe_ch;
                pend     = lat;
            end
            if (afe_sample) samp_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic read_res(input logic [3:0] c, output logic [9:0] v);
        rd_ch = c;
        #1;
        v = rd_data;
    endtask

    task automatic pulse_set();
        sw_start_set = 1'b1; tick(1); sw_start_set = 1'b0;
    endtask

    task automatic pulse_eoc_clr();
        eoc_clr = 1'b1; tick(1); eoc_clr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        do begin tick(1); n++; end while ((start_bit || converting) && n < 20000);
        chk(req, "reached idle", int'(n < 20000), 1);
    endtask

    task automatic wait_seq(input int target);
        int n = 0;
        while (seq_n < target && n < 20000) begin tick(1); n++; end
    endtask

    // Checks one completed single scan from the given start channel
    task automatic check_scan(input logic [3:0] st, input string tag);
        logic [9:0] v;
        chk(tag, "R1 conversion count", seq_n, 16 - int'(st));
        for (int i = 0; i < 16 - int'(st) && i < 64; i++)
            chk(tag, "R1 channel order", int'(seq[i]), int'(st) + i);
        chk(tag, "R3 start bit cleared", int'(start_bit), 0);
        chk(tag, "R5 eoc set", int'(eoc_flag), 1);
        for (int c = int'(st); c < 16; c++) begin
            read_res(4'(c), v);
            chk(tag, "R6 stored result", int'(v), int'(model_val(4'(c), gen)));
        end
    endtask

    task automatic single_scan(input logic [3:0] st, input logic [2:0] pr);
        cfg_start_ch = st; cfg_prescale = pr; cfg_cont = 1'b0;
        pulse_eoc_clr();
        seq_n = 0; samp_cnt = 0;
        pulse_set();
        wait_idle("R3");
    endtask

    initial begin
        logic [9:0] v;
        void'($urandom(32'd4242));
        tick(3);
        chk("R10", "start_bit at reset", int'(start_bit), 0);
        chk("R10", "converting at reset", int'(converting), 0);
        chk("R10", "eoc at reset", int'(eoc_flag), 0);
        chk("R10", "afe_start at reset", int'(afe_start), 0);
        read_res(4'd7, v);
        chk("R6", "result reset value", int'(v), 0);
        rst_n = 1'b1;
        tick(2);

        // Top channel only, P=1: one conversion, sample width 16
        gen = 6'd5;
        single_scan(4'd15, 3'd1);
        check_scan(4'd15, "R1");
        chk("R7", "sample cycles P=1", samp_cnt, 16);
        pulse_eoc_clr();
        chk("R5", "eoc cleared", int'(eoc_flag), 0);

        // Start at 3 with P=0 (treated as 1): period 56
        gen = 6'd9;
        single_scan(4'd3, 3'd0);
        check_scan(4'd3, "R1");
        chk("R7", "period P=0", per, 56);

        // P=2: period 112, sample 2*32 cycles
        gen = 6'd11;
        single_scan(4'd14, 3'd2);
        check_scan(4'd14, "R6");
        chk("R7", "period P=2", per, 112);
        chk("R7", "sample cycles P=2", samp_cnt, 64);

        // Masked triggers have no effect
        cfg_prescale = 3'd1; pulse_eoc_clr(); seq_n = 0;
        ext_trig = 1'b1; int_trig = 1'b1; tick(1); ext_trig = 1'b0; int_trig = 1'b0;
        tick(4);
        chk("R2", "masked triggers start_bit", int'(start_bit), 0);
        chk("R2", "masked triggers conversions", seq_n, 0);

        // Enabled external trigger starts; triggers during the scan ignored
        gen = 6'd17; cfg_ext_en = 1'b1; cfg_int_en = 1'b1; cfg_start_ch = 4'd10;
        ext_trig = 1'b1; tick(1); ext_trig = 1'b0;
        chk("R2", "ext trigger sets start_bit", int'(start_bit), 1);
        wait_seq(3);
        int_trig = 1'b1; ext_trig = 1'b1; sw_start_set = 1'b1; tick(1);
        int_trig = 1'b0; ext_trig = 1'b0; sw_start_set = 1'b0;
        wait_idle("R2");
        tick(5);
        chk("R2", "busy triggers ignored: conversions", seq_n, 6);
        chk("R2", "busy triggers ignored: idle", int'(converting), 0);

        // Internal trigger alone
        gen = 6'd21; cfg_ext_en = 1'b0; cfg_start_ch = 4'd15; pulse_eoc_clr(); seq_n = 0;
        int_trig = 1'b1; tick(1); int_trig = 1'b0;
        chk("R2", "int trigger sets start_bit", int'(start_bit), 1);
        wait_idle("R2");
        check_scan(4'd15, "R2");
        cfg_int_en = 1'b0;

        // Power-down blocks a start
        cfg_pdown = 1'b1; seq_n = 0;
        pulse_set();
        chk("R9", "pdown start_bit", int'(start_bit), 0);
        tick(10);
        chk("R9", "pdown conversions", seq_n, 0);
        cfg_pdown = 1'b0;

        // Power-down mid-scan acts as stop
        gen = 6'd25; cfg_start_ch = 4'd12; cfg_prescale = 3'd0; pulse_eoc_clr(); seq_n = 0;
        pulse_set();
        wait_seq(2);
        cfg_pdown = 1'b1;
        wait_idle("R9");
        tick(3);
        chk("R9", "pdown mid-scan conversions", seq_n, 2);
        chk("R9", "pdown mid-scan no eoc", int'(eoc_flag), 0);
        read_res(4'd13, v);
        chk("R9", "pdown current result stored", int'(v), int'(model_val(4'd13, gen)));
        cfg_pdown = 1'b0;

        // Continuous mode: wrap, flag each pass, stop mid-scan
        gen = 6'd33; cfg_start_ch = 4'd13; cfg_cont = 1'b1; cfg_prescale = 3'd1; seq_n = 0;
        pulse_set();
        wait_seq(8);
        for (int i = 0; i < 8; i++)
            chk("R4", "continuous order", int'(seq[i]), 13 + (i % 3));
        chk("R5", "eoc in continuous mode", int'(eoc_flag), 1);
        eoc_clr = 1'b1; sw_start_clr = 1'b1; tick(1); eoc_clr = 1'b0; sw_start_clr = 1'b0;
        wait_idle("R8");
        tick(3);
        chk("R8", "stop lets current finish only", seq_n, 8);
        chk("R8", "stop leaves eoc clear", int'(eoc_flag), 0);
        read_res(4'd14, v);
        chk("R8", "stopped conversion stored", int'(v), int'(model_val(4'd14, gen)));
        cfg_cont = 1'b0;

        // Stop and set in the same cycle: stop wins
        sw_start_set = 1'b1; sw_start_clr = 1'b1; tick(1);
        sw_start_set = 1'b0; sw_start_clr = 1'b0;
        chk("R8", "clear beats set", int'(start_bit), 0);

        // Flag set and clear colliding at the top-channel completion
        gen = 6'd37; cfg_start_ch = 4'd15; cfg_prescale = 3'd1; pulse_eoc_clr(); seq_n = 0;
        pulse_set();
        while (!afe_start) tick(1);
        repeat (55) @(negedge clk);
        eoc_clr = 1'b1;
        @(negedge clk);
        eoc_clr = 1'b0;
        #1;
        chk("R5", "set wins over clear", int'(eoc_flag), 1);
        chk("R3", "idle after collision", int'(converting), 0);

        // Slow front end stretches the conversion
        gen = 6'd41; lat = 70;
        single_scan(4'd14, 3'd1);
        check_scan(4'd14, "R11");
        chk("R11", "period with late done", per, 71);
        lat = 5;

        // Random single scans
        for (int k = 0; k < 5; k++) begin
            logic [3:0] st;
            logic [2:0] pr;
            st  = 4'($urandom_range(15, 0));
            pr  = 3'($urandom_range(3, 0));
            gen = 6'($urandom);
            single_scan(st, pr);
            check_scan(st, "R1");
            if (seq_n > 1)
                chk("R7", "random period", per, 56 * ((pr == 0) ? 1 : int'(pr)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(1_900_000);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule